// File: doc/BRIEF.md
# Criticality-Aware Dual Ready-Queue Dispatcher

This block holds ready tasks and hands them to cores that ask for work. It keeps two first-in first-out queues. Tasks marked critical go into the urgent queue, and all other tasks go into the ordinary queue. Each core belongs to one of two classes, fast or slow, which is fixed by a parameter mask.

A fast core takes urgent work first and falls back to ordinary work. A slow core takes ordinary work first. It may take urgent work only when no fast core is sitting idle. The block records a fast core as idle from the moment it is told there is no work until it next receives a task.

Cores raise a one-cycle request pulse on their own bit of a request vector. A request stays pending inside the block until it is answered. One request is answered per cycle, and the lowest-numbered pending core goes first. Each answer is either a grant that carries a task identifier or a no-task reply.

Top module: `crit_dispatch`

## Requirements
- R1: An enqueued task with a nonzero criticality value goes to the urgent queue. A task with criticality zero goes to the ordinary queue. An enqueued task is visible to requests starting the cycle after it is accepted.
- R2: A fast core (a set bit in FAST_MASK, default cores 0 and 1) is granted the head of the urgent queue when that queue is not empty.
- R3: A fast core whose urgent queue is empty is granted the head of the ordinary queue.
- R4: A slow core is granted the head of the ordinary queue when that queue is not empty.
- R5: A slow core facing an empty ordinary queue takes the urgent head only when no fast core is marked idle. Otherwise it gets a no-task reply, and the urgent queue is left unchanged.
- R6: When no queue the core may use holds a task, the reply has resp_grant=0 and resp_id=0.
- R7: Each queue hands out tasks in arrival order, and every grant removes exactly one entry.
- R8: Requests pend until answered. Exactly one reply is given per cycle, one cycle after the request is taken, and the lowest pending core index goes first. Each request gets exactly one reply.
- R9: An enqueue into a full queue (DEPTH entries) is dropped. ovf pulses high for one cycle, and the queue contents stay as they were.
- R10: fast_idle bit i is set when fast core i gets a no-task reply and cleared when it gets a grant. Bits of slow cores stay 0.
- R11: After reset both queues are empty and no request is pending. resp_valid, ovf and fast_idle are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_id | input | ID_W | Task identifier to enqueue |
| enq_crit | input | CRIT_W | Criticality value; nonzero means critical |
| req | input | NUM_CORES | One-cycle request pulse per core |
| resp_valid | output | 1 | A reply is present this cycle |
| resp_core | output | $clog2(NUM_CORES) | Core the reply is for |
| resp_grant | output | 1 | 1 = task granted, 0 = no task |
| resp_id | output | ID_W | Granted task identifier (0 on no task) |
| ovf | output | 1 | Enqueue was dropped because the queue was full |
| fast_idle | output | NUM_CORES | Idle flags of fast cores |

## Verification
The bench aims at the steal rule first. A slow core asks while a fast core is idle, and the urgent task must stay in place for that fast core to pick up later. A design that ignored the idle flag would give the task to the slow core. The idle flag is then cleared by a grant, and the same slow request must now succeed. A design that never cleared the flag would starve slow cores for good.

A burst of requests from all cores checks one-per-cycle ordering by index. A design that served two cores in one cycle, or lost a pending request, would give a missing or duplicated reply. A full ordinary queue is overfilled, then drained. A design that overwrote the oldest entry would return the dropped identifier, or would lose arrival order.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_URG  = 2'd1,
    SRC_ORD  = 2'd2
  } src_t;
endpackage

// File: rtl/dq_fifo.sv
module dq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dq_pick.sv
module dq_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]         pend,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = ($clog2(N))'(i);
      end
    end
  end
endmodule

// File: rtl/crit_dispatch.sv
module crit_dispatch #(
  parameter int                NUM_CORES = 4,
  parameter logic [NUM_CORES-1:0] FAST_MASK = 4'b0011,
  parameter int                DEPTH     = 8,
  parameter int                ID_W      = 8,
  parameter int                CRIT_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enq_valid,
  input  logic [ID_W-1:0]              enq_id,
  input  logic [CRIT_W-1:0]            enq_crit,
  input  logic [NUM_CORES-1:0]         req,
  output logic                         resp_valid,
  output logic [$clog2(NUM_CORES)-1:0] resp_core,
  output logic                         resp_grant,
  output logic [ID_W-1:0]              resp_id,
  output logic                         ovf,
  output logic [NUM_CORES-1:0]         fast_idle
);
  import dq_pkg::*;
  localparam int CORE_W = $clog2(NUM_CORES);
  localparam int CNT_W  = $clog2(DEPTH+1);

  logic                 enq_urg, enq_ord;
  logic [ID_W-1:0]      urg_head, ord_head;
  logic [CNT_W-1:0]     hp_cnt, lp_cnt;
  logic                 hp_full, lp_full, hp_empty, lp_empty;
  logic                 hp_pop, lp_pop;
  logic [NUM_CORES-1:0] pend_q, pend_all, sel_oh;
  logic                 sel_any, sel_fast;
  logic [CORE_W-1:0]    sel_core;
  src_t                 src;

  assign enq_urg = enq_valid && (enq_crit != '0);
  assign enq_ord = enq_valid && (enq_crit == '0);

  dq_fifo #(.DEPTH(DEPTH), .W(ID_W)) u_urg (
    .clk(clk), .rst(rst), .push(enq_urg), .push_data(enq_id), .pop(hp_pop),
    .head(urg_head), .count(hp_cnt), .full(hp_full), .empty(hp_empty));

  dq_fifo #(.DEPTH(DEPTH), .W(ID_W)) u_ord (
    .clk(clk), .rst(rst), .push(enq_ord), .push_data(enq_id), .pop(lp_pop),
    .head(ord_head), .count(lp_cnt), .full(lp_full), .empty(lp_empty));

  assign pend_all = pend_q | req;

  dq_pick #(.N(NUM_CORES)) u_pick (.pend(pend_all), .any(sel_any), .idx(sel_core));

  assign sel_fast = FAST_MASK[sel_core];
  assign sel_oh   = sel_any ? ({{(NUM_CORES-1){1'b0}}, 1'b1} << sel_core) : '0;

  always_comb begin
    src = SRC_NONE;
    if (sel_any) begin
      if (sel_fast) begin
        if (!hp_empty)      src = SRC_URG;
        else if (!lp_empty) src = SRC_ORD;
      end else begin
        if (!lp_empty)                           src = SRC_ORD;
        else if (!hp_empty && fast_idle == '0)   src = SRC_URG;
      end
    end
  end

  assign hp_pop = (src == SRC_URG);
  assign lp_pop = (src == SRC_ORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      resp_valid <= 1'b0;
      resp_core  <= '0;
      resp_grant <= 1'b0;
      resp_id    <= '0;
      ovf        <= 1'b0;
      fast_idle  <= '0;
    end else begin
      pend_q     <= pend_all & ~sel_oh;
      resp_valid <= sel_any;
      resp_core  <= sel_core;
      resp_grant <= (src != SRC_NONE);
      resp_id    <= hp_pop ? urg_head : (lp_pop ? ord_head : '0);
      ovf        <= (enq_urg && hp_full) || (enq_ord && lp_full);
      if (sel_any && sel_fast) fast_idle[sel_core] <= (src == SRC_NONE);
    end
  end
endmodule

// File: rtl/crit_dispatch_chk.sv
module crit_dispatch_chk #(
  parameter int                   NUM_CORES = 4,
  parameter logic [NUM_CORES-1:0] FAST_MASK = 4'b0011,
  parameter int                   DEPTH     = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         enq_valid,
  input logic                         resp_valid,
  input logic [$clog2(NUM_CORES)-1:0] resp_core,
  input logic                         resp_grant,
  input logic                         ovf,
  input logic [NUM_CORES-1:0]         fast_idle,
  input logic [$clog2(DEPTH+1)-1:0]   hp_cnt,
  input logic [$clog2(DEPTH+1)-1:0]   lp_cnt,
  input logic                         hp_full,
  input logic                         lp_full
);
  localparam int CW = $clog2(DEPTH+1);

  a_r9_bounded: assert property (@(posedge clk) disable iff (rst)
    (hp_cnt <= CW'(DEPTH)) && (lp_cnt <= CW'(DEPTH)));

  a_r9_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(enq_valid) && ($past(hp_full) || $past(lp_full)));

  a_r10_idle_set: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_grant && FAST_MASK[resp_core]) |-> fast_idle[resp_core]);

  a_r10_idle_clr: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_grant) |-> !fast_idle[resp_core]);

  a_r10_fast_only: assert property (@(posedge clk) disable iff (rst)
    (fast_idle & ~FAST_MASK) == '0);

  a_r5_steal_gate: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_grant && !FAST_MASK[resp_core] && $past(lp_cnt) == '0)
      |-> ($past(fast_idle) == '0));
endmodule

bind crit_dispatch crit_dispatch_chk #(
  .NUM_CORES(NUM_CORES), .FAST_MASK(FAST_MASK), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .enq_valid(enq_valid), .resp_valid(resp_valid),
  .resp_core(resp_core), .resp_grant(resp_grant), .ovf(ovf),
  .fast_idle(fast_idle), .hp_cnt(hp_cnt), .lp_cnt(lp_cnt),
  .hp_full(hp_full), .lp_full(lp_full));

// File: tb/sim_crit_dispatch.sv
module sim_crit_dispatch;
  localparam int NC = 4;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enq_valid = 1'b0;
  logic [7:0]    enq_id = '0;
  logic [2:0]    enq_crit = '0;
  logic [NC-1:0] req = '0;
  logic          resp_valid, resp_grant, ovf;
  logic [1:0]    resp_core;
  logic [7:0]    resp_id;
  logic [NC-1:0] fast_idle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crit_dispatch u0 (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_id(enq_id),
    .enq_crit(enq_crit), .req(req), .resp_valid(resp_valid),
    .resp_core(resp_core), .resp_grant(resp_grant), .resp_id(resp_id),
    .ovf(ovf), .fast_idle(fast_idle));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enq(input int id, input int crit);
    @(negedge clk);
    enq_valid = 1'b1; enq_id = 8'(id); enq_crit = 3'(crit);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic ask(input int core, input int grant, input int id, input string tag);
    @(negedge clk);
    req = NC'(1) << core;
    @(negedge clk);
    req = '0;
    check({tag, " valid"}, int'(resp_valid), 1);
    check({tag, " core"},  int'(resp_core), core);
    check({tag, " grant"}, int'(resp_grant), grant);
    check({tag, " id"},    int'(resp_id), id);
  endtask

  task automatic t_reset();
    check("R11 resp_valid", int'(resp_valid), 0);
    check("R11 ovf", int'(ovf), 0);
    check("R11 fast_idle", int'(fast_idle), 0);
  endtask

  task automatic t_fast();
    enq(8'h41, 2);
    enq(8'h42, 0);
    ask(0, 1, 8'h41, "R1 R2 fast takes urgent");
    ask(0, 1, 8'h42, "R3 fast falls back");
    ask(0, 0, 0, "R6 no task");
    check("R10 idle set", int'(fast_idle), 1);
  endtask

  task automatic t_slow();
    enq(8'h43, 1);
    ask(2, 0, 0, "R5 steal blocked");
    check("R10 slow not marked", int'(fast_idle), 1);
    ask(0, 1, 8'h43, "R5 urgent kept for fast");
    check("R10 idle cleared", int'(fast_idle), 0);
    enq(8'h44, 1);
    enq(8'h45, 0);
    ask(2, 1, 8'h45, "R4 slow takes ordinary");
    ask(2, 1, 8'h44, "R5 steal allowed");
  endtask

  task automatic t_fifo();
    enq(10, 0); enq(11, 0); enq(12, 0);
    ask(3, 1, 10, "R7 order 0");
    ask(3, 1, 11, "R7 order 1");
    ask(3, 1, 12, "R7 order 2");
    ask(3, 0, 0, "R6 slow empty");
  endtask

  task automatic t_burst();
    enq(20, 4); enq(21, 0); enq(22, 0);
    @(negedge clk);
    req = '1;
    @(negedge clk);
    req = '0;
    check("R8 c0 core", int'(resp_core), 0);
    check("R8 c0 id", int'(resp_id), 20);
    @(negedge clk);
    check("R8 c1 core", int'(resp_core), 1);
    check("R8 c1 id", int'(resp_id), 21);
    @(negedge clk);
    check("R8 c2 core", int'(resp_core), 2);
    check("R8 c2 id", int'(resp_id), 22);
    @(negedge clk);
    check("R8 c3 core", int'(resp_core), 3);
    check("R8 c3 grant", int'(resp_grant), 0);
    @(negedge clk);
    check("R8 single reply each", int'(resp_valid), 0);
    check("R10 after burst", int'(fast_idle), 0);
  endtask

  task automatic t_ovf();
    for (int i = 0; i < DEPTH; i++) begin
      enq(30 + i, 0);
      check("R9 no ovf while room", int'(ovf), 0);
    end
    enq(99, 0);
    check("R9 ovf pulse", int'(ovf), 1);
    @(negedge clk);
    check("R9 ovf one cycle", int'(ovf), 0);
    for (int i = 0; i < DEPTH; i++) ask(2, 1, 30 + i, "R9 R7 drain");
    ask(2, 0, 0, "R9 dropped entry absent");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_fast();
    t_slow();
    t_fifo();
    t_burst();
    t_ovf();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule